// File: doc/BRIEF.md
# Two-Level Cell Address Compression Lookup

This block turns the routing fields of an arriving cell into memory addresses for a two-level connection table. It takes the combined PHY+VPI field and a programmable path mask. It gathers the field bits that sit under the mask's ones and packs them into a dense pointer, starting at bit 0. It then reads one 32-bit first-level entry at `path_base + pointer*4`. That entry supplies a 16-bit channel mask and a 16-bit table offset. The channel mask compresses the 16-bit VCI in the same gather-and-pack way, and the block returns the address of the second-level entry.

When the unallocated-bit check is enabled, a field with a 1 in any position outside the path mask marks the cell as misinserted. Such a cell produces no memory traffic and completes at once with its flag set. The block takes one lookup at a time through a valid/ready handshake. It reads memory through a simple request/response port, and it reports each result as a single-cycle valid pulse. The configuration inputs must stay stable while a lookup is in flight.

Top module: `cell_addr_lookup`

## Requirements
- R1: After reset, `lk_ready` is 1 and both `mem_req_valid` and `res_valid` are 0.
- R2: The first-level pointer is built from the PHY+VPI bits at the positions where `cfg_path_mask` is 1, packed from bit 0 upward with the lowest mask position first. The read address is `cfg_path_base + pointer*4`. For example, mask 0x237 with field 0x011 gives pointer 0x09, and base 0x0024_0000 then gives address 0x0024_0024.
- R3: With all path-mask bits set, the pointer equals the whole field, so the first-level table spans 1024 entries.
- R4: In the 32-bit read word, bits [31:16] are the channel mask and bits [15:0] are the table offset. The result address is `cfg_chan_base + offset*4 + index*CH_ENTRY_BYTES`, with `CH_ENTRY_BYTES` = 4 by default.
- R5: The second-level index is the VCI compressed by the channel mask, using the rule of R2. A channel mask of zero gives index 0.
- R6: When `cfg_chk_unalloc` is 1 and the field has a 1 outside the path mask, `res_misins` is 1. The result is valid in the cycle after acceptance, and no memory request is issued.
- R7: When `cfg_chk_unalloc` is 0, bits outside the path mask are ignored. The lookup proceeds normally and `res_misins` is 0.
- R8: `lk_ready` is 0 from the acceptance edge until the result cycle has ended. A request offered during that time is not taken and produces neither a result nor a memory read.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and its address does not change.
- R10: `res_valid` is a one-cycle pulse. With no memory stall and a response one cycle after the request, it comes 3 cycles after acceptance, and each stall cycle adds one more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Block idle, request can be taken |
| lk_field | input | VP_W | Combined PHY+VPI field |
| lk_vci | input | CH_W | Cell VCI |
| cfg_path_mask | input | VP_W | First-level gather mask |
| cfg_path_base | input | ADDR_W | First-level table base address |
| cfg_chan_base | input | ADDR_W | Second-level region base address |
| cfg_chk_unalloc | input | 1 | Enable the unallocated-bit check |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 2*CH_W | Read data (first-level entry) |
| res_valid | output | 1 | Result pulse |
| res_addr | output | ADDR_W | Second-level entry address |
| res_misins | output | 1 | Cell flagged misinserted |

## Verification
A misinserted cell shows `res_valid` on the first falling edge after the acceptance edge. A normal lookup shows it on the third falling edge, plus one for every cycle the bench holds `mem_req_ready` low. The bench counts falling edges from acceptance and checks that the pulse lands exactly on the due edge. At that edge it compares the address and the flag, and it checks that the pulse has dropped one edge later. The memory request address is also sampled on every falling edge while the request is pending, and it is compared against the pointer arithmetic the bench works out for itself.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } cal_state_e;
endpackage

// File: rtl/cal_gather.sv
// Gather-and-pack: input bits under mask ones are packed toward bit 0.
module cal_gather #(
  parameter int W = 16
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] pack_o
);
  localparam int CW = $clog2(W + 1);

  // rank[i]: number of mask ones below bit i = output slot of bit i
  logic [CW-1:0] rank [W];

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_rank
      if (gi == 0) begin : g_first
        assign rank[gi] = '0;
      end else begin : g_rest
        assign rank[gi] = CW'($countones(mask_i[gi-1:0]));
      end
    end
  endgenerate

  always_comb begin
    pack_o = '0;
    for (int j = 0; j < W; j++) begin
      for (int i = j; i < W; i++) begin
        if (mask_i[i] && (rank[i] == CW'(j))) begin
          pack_o[j] = pack_o[j] | data_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/cal_seq.sv
// Lookup sequencer: idle -> read -> wait for data -> done.
module cal_seq
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bad_i,
  input  logic mem_req_ready_i,
  input  logic mem_rsp_valid_i,
  output logic idle_o,
  output logic mem_req_valid_o,
  output logic cap_o,
  output logic res_valid_o
);
  cal_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = bad_i ? ST_DONE : ST_READ;
      ST_READ: if (mem_req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle_o          = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_READ);
  assign cap_o           = (state_q == ST_WAIT) && mem_rsp_valid_i;
  assign res_valid_o     = (state_q == ST_DONE);
endmodule

// File: rtl/cell_addr_lookup.sv
module cell_addr_lookup #(
  parameter int ADDR_W         = 32,
  parameter int VP_W           = 10,
  parameter int CH_W           = 16,
  parameter int CH_ENTRY_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [VP_W-1:0]     lk_field,
  input  logic [CH_W-1:0]     lk_vci,
  input  logic [VP_W-1:0]     cfg_path_mask,
  input  logic [ADDR_W-1:0]   cfg_path_base,
  input  logic [ADDR_W-1:0]   cfg_chan_base,
  input  logic                cfg_chk_unalloc,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [2*CH_W-1:0]   mem_rsp_data,
  output logic                res_valid,
  output logic [ADDR_W-1:0]   res_addr,
  output logic                res_misins
);
  localparam int ENTRY_SHIFT = $clog2(CH_ENTRY_BYTES);
  localparam int PATH_SHIFT  = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic idle, start, bad, cap;
  logic [VP_W-1:0] path_ptr;
  logic [CH_W-1:0] chan_idx, chan_mask, chan_off;

  assign lk_ready  = idle;
  assign start     = lk_valid && idle;
  assign bad       = cfg_chk_unalloc && (|(lk_field & ~cfg_path_mask));
  assign chan_mask = mem_rsp_data[2*CH_W-1:CH_W];
  assign chan_off  = mem_rsp_data[CH_W-1:0];

  cal_gather #(.W(VP_W)) u_path_gather (
    .data_i (lk_field),
    .mask_i (cfg_path_mask),
    .pack_o (path_ptr)
  );

  logic [CH_W-1:0] vci_q;

  cal_gather #(.W(CH_W)) u_chan_gather (
    .data_i (vci_q),
    .mask_i (chan_mask),
    .pack_o (chan_idx)
  );

  cal_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .start_i         (start),
    .bad_i           (bad),
    .mem_req_ready_i (mem_req_ready),
    .mem_rsp_valid_i (mem_rsp_valid),
    .idle_o          (idle),
    .mem_req_valid_o (mem_req_valid),
    .cap_o           (cap),
    .res_valid_o     (res_valid)
  );

  logic [ADDR_W-1:0] rd_addr_d, res_addr_d;
  logic [ADDR_W-1:0] rd_addr_q, res_addr_q;
  logic              mis_q;

  always_comb begin
    rd_addr_d  = cfg_path_base + (ADDR_W'(path_ptr) << PATH_SHIFT);
    res_addr_d = cfg_chan_base + (ADDR_W'(chan_off) << PATH_SHIFT)
               + (ADDR_W'(chan_idx) << ENTRY_SHIFT);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_addr_q  <= '0;
      vci_q      <= '0;
      mis_q      <= 1'b0;
      res_addr_q <= '0;
    end else begin
      if (start) begin
        rd_addr_q <= rd_addr_d;
        vci_q     <= lk_vci;
        mis_q     <= bad;
      end
      if (cap) begin
        res_addr_q <= res_addr_d;
      end
    end
  end

  assign mem_req_addr = rd_addr_q;
  assign res_addr     = res_addr_q;
  assign res_misins   = mis_q;
endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
  parameter int ADDR_W = 32,
  parameter int VP_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [VP_W-1:0]   lk_field,
  input logic [VP_W-1:0]   cfg_path_mask,
  input logic              cfg_chk_unalloc,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [ADDR_W-1:0] cfg_path_base,
  input logic              res_valid,
  input logic              res_misins
);
  logic take, take_bad;
  assign take     = lk_valid && lk_ready;
  assign take_bad = take && cfg_chk_unalloc && (|(lk_field & ~cfg_path_mask));

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !res_valid && !mem_req_valid); // R1
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == cfg_path_base[1:0]); // R2
  AST_MISINS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> res_valid && res_misins); // R6
  AST_MISINS_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> !mem_req_valid); // R6
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !lk_ready); // R8
  AST_RESULT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !lk_ready && !mem_req_valid); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R10
endmodule

bind cell_addr_lookup cal_checker #(.ADDR_W(ADDR_W), .VP_W(VP_W)) u_cal_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .lk_valid        (lk_valid),
  .lk_ready        (lk_ready),
  .lk_field        (lk_field),
  .cfg_path_mask   (cfg_path_mask),
  .cfg_chk_unalloc (cfg_chk_unalloc),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .cfg_path_base   (cfg_path_base),
  .res_valid       (res_valid),
  .res_misins      (res_misins)
);

// File: tb/cell_addr_lookup_tb.sv
module cell_addr_lookup_tb_top;
  localparam logic [31:0] PBASE = 32'h0024_0000;
  localparam logic [31:0] CBASE = 32'h0100_0000;

  logic clk, rst_n;
  logic lk_valid, lk_ready, cfg_chk_unalloc;
  logic [9:0] lk_field, cfg_path_mask;
  logic [15:0] lk_vci;
  logic [31:0] cfg_path_base, cfg_chan_base;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic res_valid, res_misins;
  logic [31:0] res_addr;
  logic zero_cmask;

  int total, fails;

  cell_addr_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_field(lk_field), .lk_vci(lk_vci), .cfg_path_mask(cfg_path_mask),
    .cfg_path_base(cfg_path_base), .cfg_chan_base(cfg_chan_base),
    .cfg_chk_unalloc(cfg_chk_unalloc), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_addr(res_addr), .res_misins(res_misins)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory contents: upper half channel mask, lower half offset (R4)
  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic zc);
    logic [15:0] m;
    m = {a[9:2], a[9:2]} ^ 16'hA007;
    if (zc) m = 16'h0000;
    return {m, a[17:2] + 16'd64};
  endfunction

  function automatic logic [15:0] pack(input logic [15:0] v, input logic [15:0] m);
    logic [15:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        r[k] = v[i];
        k++;
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem_word(mem_req_addr, zero_cmask);
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic ce, input logic [9:0] m, input logic [9:0] v,
                     input logic [15:0] ci, input logic exp_mis, input int stall,
                     input logic intrude, input string tag);
    logic [31:0] a1, w, exp_res, first_addr;
    logic seen, got;
    int n, lat, exp_lat;
    a1 = PBASE + 32'(pack({6'd0, v}, {6'd0, m})) * 4;
    w = mem_word(a1, zero_cmask);
    exp_res = CBASE + 32'(w[15:0]) * 4 + 32'(pack(ci, w[31:16])) * 4;
    exp_lat = exp_mis ? 1 : 3 + stall;
    @(negedge clk);
    cfg_chk_unalloc = ce; cfg_path_mask = m; lk_field = v; lk_vci = ci;
    lk_valid = 1'b1; mem_req_ready = (stall == 0);
    check(lk_ready == 1'b1, {tag, " R8 ready before take"}, 32'(lk_ready), 1);
    @(negedge clk);
    lk_valid = intrude;
    if (intrude) lk_field = ~v;
    n = 1; got = 1'b0; seen = 1'b0; lat = 0; first_addr = '0;
    while (!got && n < 40) begin
      if (intrude && n == 1)
        check(lk_ready == 1'b0, {tag, " R8 busy"}, 32'(lk_ready), 0);
      if (mem_req_valid) begin
        if (seen)
          check(mem_req_addr == first_addr, {tag, " R9 addr held"}, mem_req_addr, first_addr);
        else first_addr = mem_req_addr;
        seen = 1'b1;
      end
      if (res_valid) begin
        got = 1'b1;
        lat = n;
      end else begin
        if (stall > 0 && n == stall + 1) mem_req_ready = 1'b1;
        n++;
        @(negedge clk);
      end
    end
    lk_valid = 1'b0;
    check(lat == exp_lat, {tag, " R10 latency"}, 32'(lat), 32'(exp_lat));
    check(res_misins == exp_mis, {tag, " R6/R7 flag"}, 32'(res_misins), 32'(exp_mis));
    if (exp_mis) begin
      check(!seen, {tag, " R6 no read"}, 32'(seen), 0);
    end else begin
      check(first_addr == a1, {tag, " R2 read addr"}, first_addr, a1);
      check(res_addr == exp_res, {tag, " R4/R5 result addr"}, res_addr, exp_res);
    end
    @(negedge clk);
    check(res_valid == 1'b0, {tag, " R10 pulse"}, 32'(res_valid), 0);
    if (intrude) begin
      for (int k = 0; k < 6; k++) begin
        check(!res_valid && !mem_req_valid, {tag, " R8 ignored"},
              {30'd0, res_valid, mem_req_valid}, 0);
        @(negedge clk);
      end
    end
    mem_req_ready = 1'b1;
  endtask

  // {chk, path_mask, field, vci, expected misinserted}
  localparam logic [37:0] VEC [8] = '{
    {1'b1, 10'h237, 10'h011, 16'h1234, 1'b0},  // R2 example
    {1'b0, 10'h3FF, 10'h3FF, 16'hFFFF, 1'b0},  // R3 full mask
    {1'b1, 10'h3FF, 10'h155, 16'h0001, 1'b0},  // R3
    {1'b1, 10'h00F, 10'h0F5, 16'hABCD, 1'b1},  // R6
    {1'b0, 10'h00F, 10'h0F5, 16'hABCD, 1'b0},  // R7
    {1'b1, 10'h000, 10'h000, 16'h5555, 1'b0},  // R2 empty mask
    {1'b1, 10'h200, 10'h200, 16'h8000, 1'b0},  // R2 top bit
    {1'b1, 10'h001, 10'h3FE, 16'h0000, 1'b1}   // R6
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    total = 0; fails = 0; zero_cmask = 1'b0;
    rst_n = 1'b0; lk_valid = 1'b0; lk_field = '0; lk_vci = '0;
    cfg_path_mask = '0; cfg_path_base = PBASE; cfg_chan_base = CBASE;
    cfg_chk_unalloc = 1'b0; mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(lk_ready == 1'b1, "R1 ready", 32'(lk_ready), 1);
    check(!mem_req_valid && !res_valid, "R1 idle outputs",
          {30'd0, mem_req_valid, res_valid}, 0);

    for (int i = 0; i < 8; i++)
      run(VEC[i][37], VEC[i][36:27], VEC[i][26:17], VEC[i][16:1], VEC[i][0], 0, 1'b0, "vec");

    // R2 worked example address
    check(PBASE + 32'(pack(16'h0011, 16'h0237)) * 4 == 32'h0024_0024, "R2 example",
          PBASE + 32'(pack(16'h0011, 16'h0237)) * 4, 32'h0024_0024);
    // R9 memory stall
    run(1'b1, 10'h237, 10'h011, 16'hBEEF, 1'b0, 4, 1'b0, "stall");
    // R5 zero channel mask gives index 0
    zero_cmask = 1'b1;
    run(1'b1, 10'h0F0, 10'h0A0, 16'hFFFF, 1'b0, 0, 1'b0, "zeromask");
    zero_cmask = 1'b0;
    // R8 request offered while busy
    run(1'b1, 10'h3C3, 10'h281, 16'h7777, 1'b0, 1, 1'b1, "intrude");
    run(1'b1, 10'h001, 10'h002, 16'h7777, 1'b1, 0, 1'b1, "intrude_mis");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule